// File: doc/BRIEF.md
# Debug-Port Whole-Flash Erase and Lock Controller

This block sits behind a debugger's access port and gives an external tool two services: erasing the entire flash array in one operation, and reporting whether the device is locked. The debugger reaches it through a parallel register strobe interface. The block has a control register at offset 0x00, a status register at offset 0x10 and a constant identification register at offset 0xFC. The flash itself is a small parameterised word array held inside the block. The core side can program it through a simple write port and observe it through a read port.

A debugger first asserts the core-reset request, then requests the erase while reset is still held. It polls until the erase bit reads back as zero, and finally writes zero to release the core. The lock state is not a register of its own. It is decoded every cycle from the last word of the flash, so the only way out of the locked state is an erase that returns that word to all ones.

Top module: `dbg_mass_erase`

## Requirements
- R1: A read at offset 0xFC returns 0x02430002.
- R2: A control write outside an erase loads bit 3 into the core-reset request. `core_rst_o` equals that request, and the control register reads it back in bit 3.
- R3: An erase starts only when a control write sets bits 0 and 3 while the reset request was already 1 before that write. Any other write with bit 0 set starts nothing and leaves the flash unchanged.
- R4: Once started, control bit 0 reads 1 for exactly `ERASE_CYCLES` clock cycles and then clears by itself.
- R5: When the erase completes, every flash word reads 0xFFFFFFFF.
- R6: Status bit 2 at offset 0x10 is 1 exactly when the last flash word is neither 0xFFFFFFFF nor 0x00000000. The other status bits read 0.
- R7: A last flash word of 0x00000000 reads as unlocked (status bit 2 = 0).
- R8: Control writes during an erase are ignored. The reset request and the erase both continue unchanged.
- R9: Core-side flash writes are ignored while `core_rst_o` is high or an erase is running. Otherwise they store the data at `fl_addr_i`.
- R10: After reset, the control and status registers read 0, `core_rst_o` is 0, every flash word reads 0xFFFFFFFF, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 8 | Register byte offset for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| core_rst_o | output | 1 | Core held in reset |
| fl_we_i | input | 1 | Core-side flash word write enable |
| fl_addr_i | input | FL_AW | Flash word index for writes and reads |
| fl_wdata_i | input | 32 | Flash write data |
| fl_rdata_o | output | 32 | Flash word at `fl_addr_i` |

## Verification
The hardest state to reach is a control write that lands while an erase is already counting. The write must arrive inside a window only `ERASE_CYCLES` long, after the reset request has been set by an earlier, separate write. The stimulus builds this in three steps. It programs a locked lock word through the core port while reset is low. It then sets the reset request on its own and issues the combined erase request. In the next cycle it issues a release write and checks that the erase still runs to its full length and that reset stays held. The ignored-request cases come first: an erase bit written without reset, and both bits written from the released state. These show that the erase only starts with reset already set.

// File: rtl/dbg_mass_erase_pkg.sv
package dbg_mass_erase_pkg;
  localparam int unsigned RW = 32;
  localparam logic [7:0]  OFF_CTRL = 8'h00;
  localparam logic [7:0]  OFF_STAT = 8'h10;
  localparam logic [7:0]  OFF_ID   = 8'hFC;
  localparam logic [RW-1:0] ID_VALUE = 32'h0243_0002;
  localparam int unsigned CTRL_ERASE_BIT = 0;
  localparam int unsigned CTRL_RST_BIT   = 3;
  localparam int unsigned STAT_LOCK_BIT  = 2;
  localparam logic [RW-1:0] WORD_BLANK = '1;
  localparam logic [RW-1:0] WORD_FW_OPEN = '0;
endpackage

// File: rtl/dme_erase_seq.sv
module dme_erase_seq #(
  parameter int unsigned ERASE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(ERASE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LAST;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dme_flash.sv
module dme_flash #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          blank_all_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic [31:0]   top_word_o
);
  logic [31:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '1;
      else if (blank_all_i)                    mem_q[g] <= '1;
      else if (we_i && addr_i == AW'(g))       mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o    = mem_q[addr_i];
  assign top_word_o = mem_q[DEPTH-1];
endmodule

// File: rtl/dme_lock_eval.sv
module dme_lock_eval
  import dbg_mass_erase_pkg::*;
(
  input  logic [RW-1:0] word_i,
  output logic          locked_o
);
  // both the blank value and the firmware-cleared value count as open
  assign locked_o = (word_i != WORD_BLANK) && (word_i != WORD_FW_OPEN);
endmodule

// File: rtl/dbg_mass_erase.sv
module dbg_mass_erase
  import dbg_mass_erase_pkg::*;
#(
  parameter int unsigned FL_DEPTH     = 16,
  parameter int unsigned ERASE_CYCLES = 16,
  localparam int unsigned FL_AW = $clog2(FL_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [RW-1:0]    reg_wdata_i,
  output logic [RW-1:0]    reg_rdata_o,
  output logic             core_rst_o,
  input  logic             fl_we_i,
  input  logic [FL_AW-1:0] fl_addr_i,
  input  logic [RW-1:0]    fl_wdata_i,
  output logic [RW-1:0]    fl_rdata_o
);
  logic rst_req_q;
  logic erase_busy, erase_done, erase_start;
  logic locked;
  logic wr_ctrl;
  logic [RW-1:0] top_word;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == OFF_CTRL) && !erase_busy;
  // erase honoured only with reset already held and kept held by this write
  assign erase_start = wr_ctrl && rst_req_q &&
                       reg_wdata_i[CTRL_RST_BIT] && reg_wdata_i[CTRL_ERASE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rst_req_q <= 1'b0;
    else if (wr_ctrl) rst_req_q <= reg_wdata_i[CTRL_RST_BIT];
  end

  assign core_rst_o = rst_req_q;

  dme_erase_seq #(.ERASE_CYCLES(ERASE_CYCLES)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (erase_start),
    .busy_o  (erase_busy),
    .done_o  (erase_done)
  );

  dme_flash #(.DEPTH(FL_DEPTH)) i_flash (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .blank_all_i (erase_done),
    .we_i        (fl_we_i && !rst_req_q && !erase_busy),
    .addr_i      (fl_addr_i),
    .wdata_i     (fl_wdata_i),
    .rdata_o     (fl_rdata_o),
    .top_word_o  (top_word)
  );

  dme_lock_eval i_lock (
    .word_i   (top_word),
    .locked_o (locked)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_CTRL: begin
        reg_rdata_o[CTRL_RST_BIT]   = rst_req_q;
        reg_rdata_o[CTRL_ERASE_BIT] = erase_busy;
      end
      OFF_STAT: reg_rdata_o[STAT_LOCK_BIT] = locked;
      OFF_ID:   reg_rdata_o = ID_VALUE;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dbg_mass_erase_chk.sv
module dbg_mass_erase_chk
  import dbg_mass_erase_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_wr_i,
  input logic [7:0]    reg_addr_i,
  input logic [RW-1:0] reg_rdata_o,
  input logic          core_rst_o,
  input logic          busy,
  input logic          locked
);
  localparam int unsigned CW = $clog2(ERASE_CYCLES + 2);
  logic [CW-1:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_len_q <= '0;
    else if (busy) busy_len_q <= busy_len_q + 1'b1;
    else           busy_len_q <= '0;
  end

  p_id_const_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFF_ID) |-> (reg_rdata_o == ID_VALUE));

  p_rst_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFF_CTRL) |-> (reg_rdata_o[CTRL_RST_BIT] == core_rst_o));

  p_erase_needs_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> ($past(core_rst_o) && core_rst_o));

  p_erase_length_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (busy_len_q == CW'(ERASE_CYCLES)));

  p_erase_unlocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !locked);

  p_busy_holds_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_wr_i) |=> $stable(core_rst_o));

  p_reset_held_in_erase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> core_rst_o);
endmodule

bind dbg_mass_erase dbg_mass_erase_chk #(.ERASE_CYCLES(ERASE_CYCLES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .core_rst_o  (core_rst_o),
  .busy        (erase_busy),
  .locked      (locked)
);

// File: tb/test_dbg_mass_erase.sv
module test_dbg_mass_erase;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int EC = 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic core_rst;
  logic fl_we = 1'b0;
  logic [AW-1:0] fl_addr = '0;
  logic [31:0] fl_wdata = '0;
  logic [31:0] fl_rdata;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int          src;   // 0 reg, 1 flash, 2 core reset
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_mass_erase #(.FL_DEPTH(DEPTH), .ERASE_CYCLES(EC)) i_dbg_mass_erase (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .core_rst_o(core_rst),
    .fl_we_i(fl_we), .fl_addr_i(fl_addr), .fl_wdata_i(fl_wdata), .fl_rdata_o(fl_rdata)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per negedge and compares
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.src)
        0: act = reg_rdata;
        1: act = fl_rdata;
        default: act = {31'b0, core_rst};
      endcase
      chk(act, it.exp, it.tag);
    end
  end

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    sb_q.push_back('{0, e, tag});
  endtask

  task automatic expect_fl(input int a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    fl_addr = AW'(a);
    sb_q.push_back('{1, e, tag});
  endtask

  task automatic expect_rst(input logic e, input string tag);
    @(posedge clk); #1;
    sb_q.push_back('{2, {31'b0, e}, tag});
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic wr_fl(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    fl_we = 1'b1; fl_addr = AW'(a); fl_wdata = d;
    @(posedge clk); #1;
    fl_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    idle(3); #1; rst_n = 1'b1;
    // R10 reset state
    expect_reg(8'h00, 32'h0, "R10 ctrl after reset");
    expect_reg(8'h10, 32'h0, "R10 stat after reset");
    expect_rst(1'b0, "R10 core reset low");
    expect_fl(0, 32'hFFFF_FFFF, "R10 flash blank");
    expect_reg(8'h04, 32'h0, "R10 unmapped offset");
    // R1
    expect_reg(8'hFC, 32'h0243_0002, "R1 id value");
    // R6/R7 lock decode, R9 normal writes
    wr_fl(3, 32'h1234_5678);
    expect_fl(3, 32'h1234_5678, "R9 write while released");
    wr_fl(DEPTH-1, 32'hFFFF_FFFE);
    expect_reg(8'h10, 32'h4, "R6 locked word");
    wr_fl(DEPTH-1, 32'h0000_0000);
    expect_reg(8'h10, 32'h0, "R7 firmware-open word");
    wr_fl(DEPTH-1, 32'hFFFF_FFFE);
    expect_reg(8'h10, 32'h4, "R6 relocked");
    // R3 erase bit alone: ignored
    wr_reg(8'h00, 32'h1);
    expect_reg(8'h00, 32'h0, "R3 erase without reset");
    idle(EC + 2);
    expect_fl(3, 32'h1234_5678, "R3 flash kept");
    // R3 both bits from released state: reset only
    wr_reg(8'h00, 32'h9);
    expect_reg(8'h00, 32'h8, "R3 combined write from released");
    expect_rst(1'b1, "R2 core reset asserted");
    idle(EC + 2);
    expect_reg(8'h10, 32'h4, "R3 still locked");
    // R9 write blocked while reset held
    wr_fl(5, 32'h0000_AAAA);
    expect_fl(5, 32'hFFFF_FFFF, "R9 write while reset held");
    // R4 erase duration
    wr_reg(8'h00, 32'h9);
    n = 0;
    while (reg_rdata[0] === 1'b1 && n < 4 * EC) begin
      @(posedge clk); #1; n++;
    end
    chk(n, EC, "R4 erase busy cycles");
    expect_reg(8'h00, 32'h8, "R4 busy cleared, reset kept");
    expect_fl(3, 32'hFFFF_FFFF, "R5 word blanked");
    expect_fl(DEPTH-1, 32'hFFFF_FFFF, "R5 lock word blanked");
    expect_reg(8'h10, 32'h0, "R5 unlocked after erase");
    // R8 writes during erase ignored
    wr_reg(8'h00, 32'h0);
    wr_fl(3, 32'h0000_00C3);
    wr_fl(DEPTH-1, 32'hFFFF_FFFE);
    wr_reg(8'h00, 32'h8);
    wr_reg(8'h00, 32'h9);
    wr_reg(8'h00, 32'h0);
    expect_reg(8'h00, 32'h9, "R8 release ignored mid-erase");
    expect_rst(1'b1, "R8 reset held mid-erase");
    idle(EC + 2);
    expect_reg(8'h00, 32'h8, "R8 erase finished");
    expect_fl(3, 32'hFFFF_FFFF, "R8 erase completed flash");
    // R2 release
    wr_reg(8'h00, 32'h0);
    expect_rst(1'b0, "R2 core reset released");
    expect_reg(8'h00, 32'h0, "R2 ctrl readback zero");
    wr_fl(5, 32'h0000_AAAA);
    expect_fl(5, 32'h0000_AAAA, "R9 write after release");
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule